// File: doc/BRIEF.md
# Alternating Two-Block Word FIFO

This block passes 16-bit words from a producer to a consumer through two storage blocks of four words each. One block is always owned by the producer side and the other by the consumer side. A block changes owner only as a whole: the producer gives up a block once it has written all four words. The consumer gives up a block once it has read all four words. A downstream DMA engine is told to read only when the block on the consumer side holds a complete set of four words.

The producer writes into its block at a position that advances with each accepted write. When that block is full, the sides exchange blocks, provided the consumer's block is empty. Otherwise the producer keeps the full block and later writes are dropped. The consumer reads the word at its own position and drains its block. After the fourth read it takes the other block if that block is full. A 16-bit status word and one-cycle error pulses report the state of both blocks. Both ports share one clock.

Top module: `dual_block_fifo`

## Requirements
- R1: After a synchronous active-low reset, both blocks are empty and both positions are 0. `dma_avail`, `both_full_status`, `wr_overflow` and `rd_underflow` are all 0, and the first four accepted writes go to the producer's block.
- R2: The fourth accepted write into the producer's block marks it full. If the other block is empty, the blocks exchange sides at that clock edge, and `dma_avail` reads 1 from the next cycle on.
- R3: A write while the producer's block is full is dropped. Stored data and the write position stay unchanged, and `wr_overflow` is 1 for exactly the following cycle.
- R4: `cons_rd_data` shows the word at the consumer's current position. Each `cons_rd_en` cycle advances that position, so words come out in write order. The fourth read marks the block empty and returns the position to 0.
- R5: When the consumer's block drains while the producer's block is full, the blocks exchange sides. `dma_avail` stays 1, and the next word read is the first word of the other block.
- R6: `both_full_status` is 16'h8080 (bits 7 and 15 set) when both blocks are full, and 16'h0000 otherwise.
- R7: `dma_avail` is 1 exactly when the consumer's block is full.
- R8: A read while the consumer's block is not full still returns the stored word and advances the position. `rd_underflow` is 1 for exactly the following cycle.
- R9: `prod_rd_data` is always 0.
- R10: If the producer's block fills while the consumer's block is still full, no exchange happens. The producer keeps its full block until the consumer drains its block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_wr_en | input | 1 | Producer write strobe |
| prod_wr_data | input | 16 | Producer write word |
| prod_rd_data | output | 16 | Read-back value of the producer port, always 0 |
| cons_rd_en | input | 1 | Consumer read strobe; advances the read position |
| cons_rd_data | output | 16 | Word at the consumer's current position |
| dma_avail | output | 1 | Consumer's block holds four words |
| both_full_status | output | 16 | 16'h8080 when both blocks are full, else 0 |
| wr_overflow | output | 1 | One-cycle pulse after a dropped write |
| rd_underflow | output | 1 | One-cycle pulse after a read of a non-full block |

## Verification
The properties assume that the strobes are 0 while reset is held and that each strobe is a clean level sampled once per clock. Under those assumptions each pulse can be traced back to the strobe of the previous cycle. The stimulus changes inputs only on the falling edge and holds both strobes low during reset. It then sweeps write and read densities from a pseudo-random sequence, so that fills, drains, simultaneous fill and drain, drops and underflows all occur with both blocks on each side.

// File: rtl/dbf_pkg.sv
// Package for the alternating two-block FIFO.
// Holds the block selector type and the fixed status encoding.
package dbf_pkg;
    typedef enum logic {BLK_A = 1'b0, BLK_B = 1'b1} blk_t;
    localparam logic [15:0] BOTH_FULL_CODE = 16'h8080;
endpackage

// File: rtl/dbf_bank.sv
// One storage block of DEPTH words.
// Has one write port and one combinational read port.
// Assumes the caller asserts wr_en only for accepted writes.
module dbf_bank #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    localparam int POS_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [POS_W-1:0]  rd_pos,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Clear all words on reset and store an accepted word at its position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_pos] <= wr_data;
        end
    end

    // Present the word at the read position.
    always_comb rd_word = mem[rd_pos];
endmodule

// File: rtl/dbf_ctrl.sv
// Ownership control for the two blocks.
// Tracks both positions and the full flag of each block. Decides when the
// two sides exchange blocks and produces the error pulses.
// Assumes the consumer block is always the one the producer does not own.
module dbf_ctrl
    import dbf_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int POS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output blk_t             wr_sel,
    output blk_t             rd_sel,
    output logic [POS_W-1:0] wr_pos,
    output logic [POS_W-1:0] rd_pos,
    output logic [1:0]       blk_full,
    output logic             accept,
    output logic             ovf,
    output logic             udf
);
    localparam logic [POS_W-1:0] LAST = POS_W'(DEPTH - 1);

    logic [1:0] full_nx;
    logic       swap;

    // The consumer always owns the block the producer does not.
    always_comb rd_sel = blk_t'(~wr_sel);

    // A write is accepted only when the producer's block has room.
    always_comb accept = push && !blk_full[wr_sel];

    // Apply fill and drain events, then check whether ownership must flip.
    always_comb begin
        full_nx = blk_full;
        if (accept && wr_pos == LAST) full_nx[wr_sel] = 1'b1;
        if (pop && rd_pos == LAST)    full_nx[rd_sel] = 1'b0;
        swap = full_nx[wr_sel] && !full_nx[rd_sel];
    end

    // State update for positions, flags, ownership and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel   <= BLK_A;
            wr_pos   <= '0;
            rd_pos   <= '0;
            blk_full <= '0;
            ovf      <= 1'b0;
            udf      <= 1'b0;
        end else begin
            blk_full <= full_nx;
            ovf      <= push && blk_full[wr_sel];
            udf      <= pop && !blk_full[rd_sel];
            if (accept) wr_pos <= (wr_pos == LAST) ? '0 : wr_pos + 1'b1;
            if (pop)    rd_pos <= (rd_pos == LAST) ? '0 : rd_pos + 1'b1;
            if (swap)   wr_sel <= rd_sel;
        end
    end
endmodule

// File: rtl/dual_block_fifo.sv
// Top of the alternating two-block word FIFO.
// Two storage blocks are used in turn by the producer and the consumer and
// change owner only as whole blocks. Outputs the DMA readiness and the
// both-full status. Assumes one clock for both sides.
module dual_block_fifo
    import dbf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_wr_en,
    input  logic [WORD_W-1:0] prod_wr_data,
    output logic [WORD_W-1:0] prod_rd_data,
    input  logic              cons_rd_en,
    output logic [WORD_W-1:0] cons_rd_data,
    output logic              dma_avail,
    output logic [15:0]       both_full_status,
    output logic              wr_overflow,
    output logic              rd_underflow
);
    localparam int POS_W = $clog2(DEPTH);

    blk_t              wr_sel, rd_sel;
    logic [POS_W-1:0]  wr_pos, rd_pos;
    logic [1:0]        blk_full;
    logic              accept;
    logic [WORD_W-1:0] bank_word [2];

    dbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(prod_wr_en), .pop(cons_rd_en),
        .wr_sel(wr_sel), .rd_sel(rd_sel), .wr_pos(wr_pos), .rd_pos(rd_pos),
        .blk_full(blk_full), .accept(accept),
        .ovf(wr_overflow), .udf(rd_underflow)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic bank_we;
        // Route an accepted write to the block the producer owns.
        always_comb bank_we = accept && (wr_sel == blk_t'(b));
        dbf_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(bank_we), .wr_pos(wr_pos),
            .wr_data(prod_wr_data), .rd_pos(rd_pos), .rd_word(bank_word[b])
        );
    end

    // Drive the outputs from the consumer's block and the two full flags.
    always_comb begin
        prod_rd_data     = '0;
        cons_rd_data     = bank_word[rd_sel];
        dma_avail        = blk_full[rd_sel];
        both_full_status = (&blk_full) ? BOTH_FULL_CODE : 16'h0000;
    end
endmodule

// File: rtl/dual_block_fifo_checker.sv
// Properties for dual_block_fifo, attached with bind.
// Assumes both strobes are low while reset is held.
module dual_block_fifo_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        prod_wr_en,
    input logic        cons_rd_en,
    input logic        dma_avail,
    input logic [15:0] both_full_status,
    input logic        wr_overflow,
    input logic        rd_underflow,
    input logic        wr_sel,
    input logic [1:0]  blk_full
);
    p_drop_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_wr_en && both_full_status != 16'h0) |=> wr_overflow);

    p_drop_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow |-> $past(prod_wr_en));

    p_no_stuck_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_full[wr_sel] && !blk_full[~wr_sel]));

    p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (both_full_status == 16'h0000) || (both_full_status == 16'h8080));

    p_status_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (both_full_status != 16'h0) |-> dma_avail);

    p_short_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_rd_en && !dma_avail) |=> rd_underflow);

    p_short_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_underflow |-> $past(cons_rd_en));
endmodule

bind dual_block_fifo dual_block_fifo_checker u_chk (
    .clk(clk), .rst_n(rst_n), .prod_wr_en(prod_wr_en), .cons_rd_en(cons_rd_en),
    .dma_avail(dma_avail), .both_full_status(both_full_status),
    .wr_overflow(wr_overflow), .rd_underflow(rd_underflow),
    .wr_sel(wr_sel), .blk_full(blk_full)
);

// File: tb/dual_block_fifo_tb.sv
`timescale 1ns/1ps
module dual_block_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prod_wr_en = 1'b0;
    logic [15:0] prod_wr_data = '0;
    logic [15:0] prod_rd_data;
    logic        cons_rd_en = 1'b0;
    logic [15:0] cons_rd_data;
    logic        dma_avail;
    logic [15:0] both_full_status;
    logic        wr_overflow;
    logic        rd_underflow;

    int n_run = 0;
    int n_fail = 0;

    // Expected state, written from the requirements.
    logic [15:0] m_mem [2][4];
    logic        m_full [2];
    int          m_ws, m_wp, m_rp;
    logic        m_ovf, m_udf;

    always #2 clk = ~clk;

    dual_block_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .prod_wr_en(prod_wr_en),
        .prod_wr_data(prod_wr_data), .prod_rd_data(prod_rd_data),
        .cons_rd_en(cons_rd_en), .cons_rd_data(cons_rd_data),
        .dma_avail(dma_avail), .both_full_status(both_full_status),
        .wr_overflow(wr_overflow), .rd_underflow(rd_underflow)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            m_full[b] = 1'b0;
            for (int i = 0; i < 4; i++) m_mem[b][i] = '0;
        end
        m_ws = 0; m_wp = 0; m_rp = 0; m_ovf = 1'b0; m_udf = 1'b0;
    endtask

    // Compare every output against the expected state, just before the edge.
    task automatic compare_all();
        int rs;
        rs = 1 - m_ws;
        check("R4 read word", cons_rd_data, m_mem[rs][m_rp]);
        check("R7 dma_avail", {15'b0, dma_avail}, {15'b0, m_full[rs]});
        check("R6 status", both_full_status, (m_full[0] && m_full[1]) ? 16'h8080 : 16'h0000);
        check("R3 overflow pulse", {15'b0, wr_overflow}, {15'b0, m_ovf});
        check("R8 underflow pulse", {15'b0, rd_underflow}, {15'b0, m_udf});
        check("R9 producer readback", prod_rd_data, 16'h0000);
    endtask

    // One cycle: drive on the falling edge, check, then advance the model past the rising edge.
    task automatic step(input logic wr, input logic [15:0] wd, input logic rd);
        logic nf [2];
        int   rs;
        @(negedge clk);
        prod_wr_en = wr; prod_wr_data = wd; cons_rd_en = rd;
        #1;
        compare_all();
        @(posedge clk);
        rs = 1 - m_ws;
        nf[0] = m_full[0]; nf[1] = m_full[1];
        m_ovf = wr && m_full[m_ws];
        m_udf = rd && !m_full[rs];
        if (wr && !m_full[m_ws]) begin
            m_mem[m_ws][m_wp] = wd;
            if (m_wp == 3) begin nf[m_ws] = 1'b1; m_wp = 0; end
            else m_wp++;
        end
        if (rd) begin
            if (m_rp == 3) begin nf[rs] = 1'b0; m_rp = 0; end
            else m_rp++;
        end
        m_full[0] = nf[0]; m_full[1] = nf[1];
        if (m_full[m_ws] && !m_full[rs]) m_ws = rs;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; prod_wr_en = 1'b0; cons_rd_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        do_reset();
        #1;
        // R1: reset state
        check("R1 dma_avail after reset", {15'b0, dma_avail}, 16'h0);
        check("R1 status after reset", both_full_status, 16'h0);
        check("R1 pulses after reset", {14'b0, wr_overflow, rd_underflow}, 16'h0);

        // R2: four writes fill the producer block and hand it over
        for (int i = 0; i < 4; i++) step(1'b1, 16'h1000 + 16'(i), 1'b0);
        step(1'b0, '0, 1'b0);
        check("R2 dma_avail after fill", {15'b0, dma_avail}, 16'h1);
        check("R2 first word", cons_rd_data, 16'h1000);

        // R10: second block fills while first still full, then drop (R3)
        for (int i = 0; i < 4; i++) step(1'b1, 16'h2000 + 16'(i), 1'b0);
        step(1'b0, '0, 1'b0);
        check("R6 both full code", both_full_status, 16'h8080);
        step(1'b1, 16'hDEAD, 1'b0);
        step(1'b0, '0, 1'b0);
        check("R10 no exchange, still both full", both_full_status, 16'h8080);

        // R4/R5: drain first block, the other becomes readable at once
        for (int i = 0; i < 4; i++) begin
            step(1'b0, '0, 1'b0);
            check("R4 ordered read", cons_rd_data, 16'h1000 + 16'(i));
            step(1'b0, '0, 1'b1);
        end
        step(1'b0, '0, 1'b0);
        check("R5 avail after exchange", {15'b0, dma_avail}, 16'h1);
        check("R5 next block first word", cons_rd_data, 16'h2000);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        check("R4 empty after drain", {15'b0, dma_avail}, 16'h0);

        // R8: read of a non-full block
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);

        // Sweep of write/read densities with simultaneous events
        lfsr = 16'hACE1;
        for (int phase = 0; phase < 4; phase++) begin
            do_reset();
            for (int c = 0; c < 1500; c++) begin
                logic w, r;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (phase)
                    0: begin w = lfsr[0] | lfsr[1]; r = lfsr[2] & lfsr[3]; end
                    1: begin w = lfsr[0] & lfsr[1]; r = lfsr[2] | lfsr[3]; end
                    2: begin w = lfsr[0]; r = lfsr[5]; end
                    default: begin w = 1'b1; r = lfsr[4] | (c[6]); end
                endcase
                step(w, lfsr ^ 16'(c), r);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule